// File: doc/BRIEF.md
# Event/Tick Counter with Falling-Edge Capture

This block is a 16-bit up-counter that a processor reaches through a small byte-wide register port. The counter advances either on a fixed division of the system clock or on falling edges seen on an external count pin, and it advances only while its run control is set. When it rolls past its maximum value it returns to zero and raises a sticky overflow flag.

With capture armed, a high-to-low transition on a second external pin freezes the live count into a 16-bit capture register and raises a sticky capture flag. Both flags feed one registered interrupt line. Software finds the cause by reading the control register, then writes the flag bits to zero to drop the request. Both external pins are resynchronised to the system clock before their edges are detected, so they may change at any time.

Top module: `evt_capture_timer`

## Requirements
- R1: After a synchronous reset every register reads 0x00 and `irq` is low.
- R2: Register map, read data valid on `reg_rdata` one clock after the address is presented: address 0 is control (bit0 run, bit1 source select, bit2 capture arm, bit6 overflow flag, bit7 capture flag; bits 3 to 5 read 0), addresses 1 and 2 are the count low and high bytes (read/write), addresses 3 and 4 are the capture low and high bytes (read-only), and every other address reads 0x00.
- R3: With source select 0 and run set, the count increments once every 12 clock cycles.
- R4: With source select 1 and run set, the count increments once per falling edge of `cnt_pin` (each level held at least 2 clocks), with carry between the bytes.
- R5: With run clear, the count holds its value whatever the pins do.
- R6: An increment from 0xFFFF gives 0x0000 and sets the overflow flag.
- R7: With capture armed, a falling edge on `cap_pin` copies the count into the capture register and sets the capture flag.
- R8: With capture not armed, falling edges on `cap_pin` leave the capture register and the capture flag unchanged.
- R9: When a capture and an increment fall in the same clock, the capture register receives the count from before that increment.
- R10: Neither flag clears by itself; each stays set until a control write with that bit at 0.
- R11: `irq` is high exactly when at least one of the two flags is set, and changes on the same clock edge as the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the addressed register |
| cnt_pin | input | 1 | External event input, counted on falling edges |
| cap_pin | input | 1 | Capture trigger input, active on falling edges |
| irq | output | 1 | Interrupt request, OR of the two sticky flags |

## Verification
The hardest case to reach from the ports is a capture landing in exactly the clock where the counter also steps, because the capture pin and the clock-divided or pin-driven increment run on separate paths with their own delays. The bench reaches it in event-count mode by driving both external pins low on the same falling clock edge; since both pass through synchronisers of equal depth, their edges are detected in the same cycle, and the capture register must then hold the count from before the step while the count itself moves on by one.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned TICK_DIV = 12;
  localparam int unsigned SYNC_LEN = 2;

  // address of the control register and base of the count bytes
  localparam int unsigned ADR_CTRL     = 0;
  localparam int unsigned ADR_CNT_BASE = 1;

  // control register bit positions
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_SRC  = 1;
  localparam int unsigned BIT_ARM  = 2;
  localparam int unsigned BIT_OVF  = 6;
  localparam int unsigned BIT_CAPF = 7;

  typedef enum logic {SRC_TICK = 1'b0, SRC_PIN = 1'b1} src_e;

  typedef struct packed {
    logic run;
    src_e src;
    logic arm;
  } ctrl_t;
endpackage

// File: rtl/ect_prescale.sv
module ect_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = en && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/ect_fall_detect.sv
module ect_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic fall_o
);
  // sh[0..STAGES-1] synchroniser, sh[STAGES] previous synchronised level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '1;
    end else begin
      sh_q <= {sh_q[STAGES-1:0], pin_i};
    end
  end

  assign fall_o = sh_q[STAGES] && !sh_q[STAGES-1];
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int unsigned CW = 16,
  parameter int unsigned BW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [CW/BW-1:0] wr_be,
  input  logic [BW-1:0]    wr_data,
  input  logic             cap_stb,
  output logic [CW-1:0]    cnt,
  output logic [CW-1:0]    cap,
  output logic             wrap
);
  localparam int unsigned NB = CW / BW;

  logic sw_write;
  assign sw_write = |wr_be;
  assign wrap     = inc && !sw_write && (cnt == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (sw_write) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_be[b]) cnt[b*BW +: BW] <= wr_data;
      end
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  // snapshot takes the value held before this edge's update
  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
    end else if (cap_stb) begin
      cap <= cnt;
    end
  end
endmodule

// File: rtl/evt_capture_timer.sv
module evt_capture_timer
  import ect_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = REG_W,
  parameter int unsigned CW  = CNT_W,
  parameter int unsigned DIV = TICK_DIV,
  parameter int unsigned SYN = SYNC_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cnt_pin,
  input  logic          cap_pin,
  output logic          irq
);
  localparam int unsigned NB       = CW / DW;
  localparam int unsigned CAP_BASE = ADR_CNT_BASE + NB;
  localparam int unsigned NPIN     = 2;
  localparam int unsigned PIN_CNT  = 0;
  localparam int unsigned PIN_CAP  = 1;

  ctrl_t          ctrl_q;
  logic           ovf_q, capf_q;
  logic           flag_we;
  logic           tick, inc, wrap;
  logic [NB-1:0]  cnt_be;
  logic [CW-1:0]  cnt_q, cap_q;
  logic [NPIN-1:0] pins, falls;
  logic           cnt_fall, cap_fall, cap_stb;
  logic           run_q, arm_q;

  assign run_q = ctrl_q.run;
  assign arm_q = ctrl_q.arm;

  // ---------------- pin synchronisers ----------------
  assign pins[PIN_CNT] = cnt_pin;
  assign pins[PIN_CAP] = cap_pin;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    ect_fall_detect #(.STAGES(SYN)) i_fall (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pins[p]),
      .fall_o (falls[p])
    );
  end

  assign cnt_fall = falls[PIN_CNT];
  assign cap_fall = falls[PIN_CAP];
  assign cap_stb  = cap_fall && arm_q;

  // ---------------- increment source ----------------
  ect_prescale #(.DIV(DIV)) i_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (run_q && (ctrl_q.src == SRC_TICK)),
    .tick (tick)
  );

  assign inc = run_q && ((ctrl_q.src == SRC_PIN) ? cnt_fall : tick);

  // ---------------- count byte write enables ----------------
  for (genvar b = 0; b < NB; b++) begin : g_be
    assign cnt_be[b] = reg_wr && (reg_addr == AW'(ADR_CNT_BASE + b));
  end

  ect_counter #(.CW(CW), .BW(DW)) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc),
    .wr_be   (cnt_be),
    .wr_data (reg_wdata),
    .cap_stb (cap_stb),
    .cnt     (cnt_q),
    .cap     (cap_q),
    .wrap    (wrap)
  );

  // ---------------- control and flags ----------------
  assign flag_we = reg_wr && (reg_addr == AW'(ADR_CTRL));

  logic ovf_n, capf_n;

  always_comb begin
    ovf_n  = flag_we ? reg_wdata[BIT_OVF]  : ovf_q;
    capf_n = flag_we ? reg_wdata[BIT_CAPF] : capf_q;
    if (wrap)    ovf_n  = 1'b1;
    if (cap_stb) capf_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{run: 1'b0, src: SRC_TICK, arm: 1'b0};
      ovf_q  <= 1'b0;
      capf_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (flag_we) begin
        ctrl_q.run <= reg_wdata[BIT_RUN];
        ctrl_q.src <= src_e'(reg_wdata[BIT_SRC]);
        ctrl_q.arm <= reg_wdata[BIT_ARM];
      end
      ovf_q  <= ovf_n;
      capf_q <= capf_n;
      irq    <= ovf_n || capf_n;
    end
  end

  // ---------------- registered read port ----------------
  logic [DW-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    if (reg_addr == AW'(ADR_CTRL)) begin
      rd_n[BIT_RUN]  = ctrl_q.run;
      rd_n[BIT_SRC]  = ctrl_q.src;
      rd_n[BIT_ARM]  = ctrl_q.arm;
      rd_n[BIT_OVF]  = ovf_q;
      rd_n[BIT_CAPF] = capf_q;
    end
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == AW'(ADR_CNT_BASE + b)) rd_n = cnt_q[b*DW +: DW];
      if (reg_addr == AW'(CAP_BASE + b))     rd_n = cap_q[b*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int unsigned CW = 16,
  parameter int unsigned NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          inc,
  input logic [NB-1:0] cnt_be,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic          cap_fall,
  input logic          arm,
  input logic          ovf,
  input logic          capf,
  input logic          flag_we,
  input logic          irq
);
  logic cnt_we;
  assign cnt_we = |cnt_be;

  // R3 / R4: one step per increment
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !cnt_we) |=> (cnt == $past(cnt) + 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> (cnt == $past(cnt)));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && !cnt_we && (cnt == {CW{1'b1}})) |=> (cnt == '0 && ovf));

  // R7 and R9: snapshot is the pre-update count
  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (cap_fall && arm) |=> (cap == $past(cnt) && capf));

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (cap_fall && !arm) |=> $stable(cap));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flag_we) |=> ovf);

  p_capf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (capf && !flag_we) |=> capf);

  p_irq_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == (ovf || capf)));
endmodule

bind evt_capture_timer ect_checker #(.CW(CW), .NB(NB)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run_q),
  .inc      (inc),
  .cnt_be   (cnt_be),
  .cnt      (cnt_q),
  .cap      (cap_q),
  .cap_fall (cap_fall),
  .arm      (arm_q),
  .ovf      (ovf_q),
  .capf     (capf_q),
  .flag_we  (flag_we),
  .irq      (irq)
);

// File: tb/test_evt_capture_timer.sv
module test_evt_capture_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_pin = 1'b1;
  logic       cap_pin = 1'b1;
  logic       irq;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  evt_capture_timer i_evt_capture_timer (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cnt_pin   (cnt_pin),
    .cap_pin   (cap_pin),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic pulse_cnt();
    @(negedge clk); cnt_pin = 1'b0;
    repeat (3) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap_pin = 1'b0;
    repeat (3) @(negedge clk);
    cap_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // {write, addr[2:0], data[7:0]}; reads compare data
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 3'd1, 8'h34}, {1'b1, 3'd2, 8'h12},
    {1'b0, 3'd1, 8'h34}, {1'b0, 3'd2, 8'h12},
    {1'b1, 3'd0, 8'h06}, {1'b0, 3'd0, 8'h06},
    {1'b0, 3'd3, 8'h00}, {1'b0, 3'd5, 8'h00},
    {1'b0, 3'd7, 8'h00}, {1'b1, 3'd0, 8'h38},
    {1'b0, 3'd0, 8'h00}, {1'b1, 3'd3, 8'hAA}
  };

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      chk("R1", 16'(b), 16'h0000);
    end
    chk("R1 irq", 16'(irq), 16'h0000);

    // R2: register map table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11]) wr(VEC[i][10:8], VEC[i][7:0]);
      else begin
        rd(VEC[i][10:8], b);
        chk("R2", 16'(b), 16'(VEC[i][7:0]));
      end
    end
    rd(3'd3, b);
    chk("R2 capture read-only", 16'(b), 16'h0000);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // R3: clock-divided counting, 124 edges of run -> 10 steps
    wr(3'd0, 8'h01);
    repeat (123) @(posedge clk);
    wr(3'd0, 8'h00);
    rd16(3'd1, v);
    chk("R3", v, 16'd10);

    // R4: pin counting with byte carry
    wr(3'd1, 8'hFE); wr(3'd2, 8'h00);
    wr(3'd0, 8'h03);
    pulse_cnt(); pulse_cnt(); pulse_cnt();
    rd16(3'd1, v);
    chk("R4", v, 16'h0101);

    // R5: stopped counter ignores pin edges
    wr(3'd0, 8'h02);
    pulse_cnt(); pulse_cnt();
    rd16(3'd1, v);
    chk("R5", v, 16'h0101);

    // R6: wrap and overflow flag
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h03);
    pulse_cnt();
    rd16(3'd1, v);
    chk("R6 count", v, 16'h0000);
    rd(3'd0, b);
    chk("R6 flag", 16'(b), 16'h0043);
    chk("R11 set", 16'(irq), 16'h0001);

    // R10: flag persists, then clears by write
    repeat (40) @(negedge clk);
    rd(3'd0, b);
    chk("R10 sticky", 16'(b), 16'h0043);
    wr(3'd0, 8'h03);
    chk("R11 clear", 16'(irq), 16'h0000);
    rd(3'd0, b);
    chk("R10 cleared", 16'(b), 16'h0003);

    // R7: armed capture
    wr(3'd0, 8'h07);
    pulse_cnt(); pulse_cnt(); pulse_cnt(); pulse_cnt(); pulse_cnt();
    pulse_cap();
    rd16(3'd3, v);
    chk("R7 value", v, 16'h0005);
    rd(3'd0, b);
    chk("R7 flag", 16'(b), 16'h0087);
    chk("R11 capture", 16'(irq), 16'h0001);

    // R9: capture and increment in the same clock
    @(negedge clk); cnt_pin = 1'b0; cap_pin = 1'b0;
    repeat (3) @(negedge clk);
    cnt_pin = 1'b1; cap_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd16(3'd3, v);
    chk("R9 capture", v, 16'h0005);
    rd16(3'd1, v);
    chk("R9 count", v, 16'h0006);

    // R8: disarmed capture pin has no effect
    wr(3'd0, 8'h03);
    pulse_cap();
    rd16(3'd3, v);
    chk("R8 value", v, 16'h0005);
    rd(3'd0, b);
    chk("R8 flag", 16'(b), 16'h0003);
    chk("R8 irq", 16'(irq), 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule